// File: doc/BRIEF.md
# Dual Masked Calendar Alarm Comparator

This block watches a running calendar (subseconds, seconds, minutes, hours, day-of-month and weekday) and compares it every clock cycle against two separately programmed alarm settings, called A and B. Each alarm carries five don't-care bits, one per compared field, so an alarm can fire every second, every minute, once a day or at one exact instant. The last field of each alarm is compared either against the day-of-month or against the weekday, chosen per alarm.

When all unmasked fields of an alarm equal the calendar, the alarm's sticky flag is set on the first cycle of that equality only. Software clears the flag through a clear strobe. Each flag can be gated onto a shared interrupt request, and a two-bit selector routes alarm A, alarm B or an auxiliary event onto one external pin whose active level is programmable. The calendar counter and the register bus sit outside this block.

Top module: `dual_alarm_cmp`

## Requirements
- R1: After reset both flags, the interrupt request and the internal match history are cleared; alarms A and B set only their own flag.
- R2: An alarm's flag reads 1 one clock edge after the calendar first equals all its unmasked fields; field mask bit order is bit0 subseconds, bit1 seconds, bit2 minutes, bit3 hours, bit4 day.
- R3: A field whose mask bit is 1 is left out of the comparison; with all five mask bits set the alarm matches regardless of the calendar.
- R4: A flag is set only on the first cycle of a match; a match that stays true does not set the flag again after it has been cleared.
- R5: A clear strobe drops the flag after the next edge; if a new match starts in the same cycle the set wins.
- R6: Day-select 0 compares the 5-bit alarm day with the day-of-month; day-select 1 compares its low 3 bits with the weekday.
- R7: The interrupt request is high whenever some flag is 1 together with that alarm's interrupt enable.
- R8: Pin selector 00 holds the pin inactive, 01 follows flag A, 10 follows flag B, 11 follows the auxiliary event input.
- R9: Polarity 0 makes the pin active high; polarity 1 makes it active low (inactive level 1).
- R10: With the seconds field unmasked on an alarm, the synchronous prescaler divider must be at least 3; smaller values are unsupported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_subsec | input | SS_W | Calendar subsecond count |
| cal_sec | input | 6 | Calendar seconds |
| cal_min | input | 6 | Calendar minutes |
| cal_hour | input | 5 | Calendar hours |
| cal_date | input | 5 | Calendar day of month |
| cal_wday | input | 3 | Calendar weekday |
| presc_div | input | PD_W | Synchronous prescaler division factor |
| a_subsec | input | SS_W | Alarm A subseconds |
| a_sec | input | 6 | Alarm A seconds |
| a_min | input | 6 | Alarm A minutes |
| a_hour | input | 5 | Alarm A hours |
| a_day | input | 5 | Alarm A day (date or weekday) |
| a_wdsel | input | 1 | Alarm A day-select |
| a_mask | input | 5 | Alarm A field masks |
| a_ie | input | 1 | Alarm A interrupt enable |
| a_clr | input | 1 | Alarm A flag clear strobe |
| b_subsec | input | SS_W | Alarm B subseconds |
| b_sec | input | 6 | Alarm B seconds |
| b_min | input | 6 | Alarm B minutes |
| b_hour | input | 5 | Alarm B hours |
| b_day | input | 5 | Alarm B day (date or weekday) |
| b_wdsel | input | 1 | Alarm B day-select |
| b_mask | input | 5 | Alarm B field masks |
| b_ie | input | 1 | Alarm B interrupt enable |
| b_clr | input | 1 | Alarm B flag clear strobe |
| pin_sel | input | 2 | External pin source select |
| pin_pol | input | 1 | External pin polarity |
| aux_evt | input | 1 | Auxiliary event for selector 11 |
| flag_a | output | 1 | Alarm A flag |
| flag_b | output | 1 | Alarm B flag |
| irq | output | 1 | Interrupt request |
| alarm_pin | output | 1 | External alarm pin |

## Verification
The assertions take for granted that whenever an alarm compares seconds the prescaler divider is at least 3, and that clear strobes and configuration change only between clock edges. The stimulus keeps the divider at 255 throughout and drives every input on the falling edge, so the seconds comparison is always in its supported range and every flag transition is observed half a cycle after the edge that makes it.

// File: rtl/alarm_pkg.sv
// Shared constants for the dual alarm comparator.
// Assumes five compared fields in a fixed mask bit order.
package alarm_pkg;
    localparam int NUM_FIELDS = 5;
    localparam int FLD_SUBSEC = 0;
    localparam int FLD_SEC    = 1;
    localparam int FLD_MIN    = 2;
    localparam int FLD_HOUR   = 3;
    localparam int FLD_DAY    = 4;

    typedef enum logic [1:0] {
        PIN_OFF = 2'b00,
        PIN_A   = 2'b01,
        PIN_B   = 2'b10,
        PIN_AUX = 2'b11
    } pin_sel_e;
endpackage

// File: rtl/alarm_match.sv
// Field comparator for one alarm: flags equality per field, then
// treats masked fields as equal. Purely combinational.
// Assumes calendar and alarm fields use the same binary encoding.
module alarm_match
    import alarm_pkg::*;
#(
    parameter int SS_W = 15
) (
    input  logic [SS_W-1:0]       cal_subsec,
    input  logic [5:0]            cal_sec,
    input  logic [5:0]            cal_min,
    input  logic [4:0]            cal_hour,
    input  logic [4:0]            cal_date,
    input  logic [2:0]            cal_wday,
    input  logic [SS_W-1:0]       alm_subsec,
    input  logic [5:0]            alm_sec,
    input  logic [5:0]            alm_min,
    input  logic [4:0]            alm_hour,
    input  logic [4:0]            alm_day,
    input  logic                  alm_wdsel,
    input  logic [NUM_FIELDS-1:0] alm_mask,
    output logic                  hit
);
    logic [NUM_FIELDS-1:0] fld_eq;
    logic                  day_eq;

    // Day comparison: day-of-month or weekday per the day-select bit.
    always_comb begin
        if (alm_wdsel) day_eq = (alm_day[2:0] == cal_wday);
        else           day_eq = (alm_day == cal_date);
    end

    // Per-field equality vector in mask bit order.
    always_comb begin
        fld_eq             = '0;
        fld_eq[FLD_SUBSEC] = (alm_subsec == cal_subsec);
        fld_eq[FLD_SEC]    = (alm_sec == cal_sec);
        fld_eq[FLD_MIN]    = (alm_min == cal_min);
        fld_eq[FLD_HOUR]   = (alm_hour == cal_hour);
        fld_eq[FLD_DAY]    = day_eq;
    end

    // Alarm hit: every field is equal or masked.
    assign hit = &(fld_eq | alm_mask);

    always_comb begin
        if (alm_mask == '1) AST_ALL_MASKED_HIT: assert (hit); // R3
    end
endmodule

// File: rtl/alarm_flag.sv
// Sticky flag for one alarm: set on the first cycle of a hit,
// cleared by a strobe; a simultaneous new hit wins over the clear.
// Assumes hit is synchronous to clk.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    logic hit_q;
    logic hit_rise;

    assign hit_rise = hit & ~hit_q;

    // Hit history for first-cycle detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    // Flag register: set on rise, else clear on strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit_rise) flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end

    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !$past(hit)) |=> flag); // R2
    AST_NO_RESET_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hit) && hit && !flag) |=> !flag); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag); // R5
endmodule

// File: rtl/alarm_out.sv
// Output stage: merges enabled flags into the interrupt request and
// routes the selected source onto the external pin with polarity.
// Assumes all inputs are registered or static configuration.
module alarm_out
    import alarm_pkg::*;
(
    input  logic [1:0] pin_sel,
    input  logic       pin_pol,
    input  logic       aux_evt,
    input  logic       flag_a,
    input  logic       flag_b,
    input  logic       ie_a,
    input  logic       ie_b,
    output logic       irq,
    output logic       pin
);
    logic pin_active;

    // Interrupt request from enabled flags.
    assign irq = (flag_a & ie_a) | (flag_b & ie_b);

    // Pin source selection.
    always_comb begin
        case (pin_sel_e'(pin_sel))
            PIN_A:   pin_active = flag_a;
            PIN_B:   pin_active = flag_b;
            PIN_AUX: pin_active = aux_evt;
            default: pin_active = 1'b0;
        endcase
    end

    // Polarity: 1 makes the pin active low.
    assign pin = pin_active ^ pin_pol;
endmodule

// File: rtl/dual_alarm_cmp.sv
// Top: two masked calendar alarms with flags, an interrupt request
// and a routed external pin. Assumes the calendar inputs are
// synchronous to clk and the prescaler divider obeys R10.
module dual_alarm_cmp
    import alarm_pkg::*;
#(
    parameter int SS_W = 15,
    parameter int PD_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SS_W-1:0] cal_subsec,
    input  logic [5:0]      cal_sec,
    input  logic [5:0]      cal_min,
    input  logic [4:0]      cal_hour,
    input  logic [4:0]      cal_date,
    input  logic [2:0]      cal_wday,
    input  logic [PD_W-1:0] presc_div,
    input  logic [SS_W-1:0] a_subsec,
    input  logic [5:0]      a_sec,
    input  logic [5:0]      a_min,
    input  logic [4:0]      a_hour,
    input  logic [4:0]      a_day,
    input  logic            a_wdsel,
    input  logic [4:0]      a_mask,
    input  logic            a_ie,
    input  logic            a_clr,
    input  logic [SS_W-1:0] b_subsec,
    input  logic [5:0]      b_sec,
    input  logic [5:0]      b_min,
    input  logic [4:0]      b_hour,
    input  logic [4:0]      b_day,
    input  logic            b_wdsel,
    input  logic [4:0]      b_mask,
    input  logic            b_ie,
    input  logic            b_clr,
    input  logic [1:0]      pin_sel,
    input  logic            pin_pol,
    input  logic            aux_evt,
    output logic            flag_a,
    output logic            flag_b,
    output logic            irq,
    output logic            alarm_pin
);
    localparam int NUM_ALM = 2;

    logic [NUM_ALM-1:0][SS_W-1:0]       alm_subsec;
    logic [NUM_ALM-1:0][5:0]            alm_sec;
    logic [NUM_ALM-1:0][5:0]            alm_min;
    logic [NUM_ALM-1:0][4:0]            alm_hour;
    logic [NUM_ALM-1:0][4:0]            alm_day;
    logic [NUM_ALM-1:0]                 alm_wdsel;
    logic [NUM_ALM-1:0][NUM_FIELDS-1:0] alm_mask;
    logic [NUM_ALM-1:0]                 alm_clr;
    logic [NUM_ALM-1:0]                 alm_hit;
    logic [NUM_ALM-1:0]                 alm_flag;

    // Pack alarm configuration into per-alarm arrays.
    always_comb begin
        alm_subsec = {b_subsec, a_subsec};
        alm_sec    = {b_sec, a_sec};
        alm_min    = {b_min, a_min};
        alm_hour   = {b_hour, a_hour};
        alm_day    = {b_day, a_day};
        alm_wdsel  = {b_wdsel, a_wdsel};
        alm_mask   = {b_mask, a_mask};
        alm_clr    = {b_clr, a_clr};
    end

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
        alarm_match #(.SS_W(SS_W)) match_i (
            .cal_subsec (cal_subsec),
            .cal_sec    (cal_sec),
            .cal_min    (cal_min),
            .cal_hour   (cal_hour),
            .cal_date   (cal_date),
            .cal_wday   (cal_wday),
            .alm_subsec (alm_subsec[g]),
            .alm_sec    (alm_sec[g]),
            .alm_min    (alm_min[g]),
            .alm_hour   (alm_hour[g]),
            .alm_day    (alm_day[g]),
            .alm_wdsel  (alm_wdsel[g]),
            .alm_mask   (alm_mask[g]),
            .hit        (alm_hit[g])
        );
        alarm_flag flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (alm_hit[g]),
            .clr   (alm_clr[g]),
            .flag  (alm_flag[g])
        );
    end

    assign flag_a = alm_flag[0];
    assign flag_b = alm_flag[1];

    alarm_out out_i (
        .pin_sel (pin_sel),
        .pin_pol (pin_pol),
        .aux_evt (aux_evt),
        .flag_a  (alm_flag[0]),
        .flag_b  (alm_flag[1]),
        .ie_a    (a_ie),
        .ie_b    (b_ie),
        .irq     (irq),
        .pin     (alarm_pin)
    );

    AST_PRESC_SEC_A: assert property (@(posedge clk) disable iff (!rst_n)
        !a_mask[FLD_SEC] |-> (presc_div >= PD_W'(3))); // R10
    AST_PRESC_SEC_B: assert property (@(posedge clk) disable iff (!rst_n)
        !b_mask[FLD_SEC] |-> (presc_div >= PD_W'(3))); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ie && !b_ie) |-> !irq); // R7
    AST_PIN_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == 2'b00) |-> (alarm_pin == pin_pol)); // R8
    AST_PIN_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_sel == 2'b01) |-> (alarm_pin == (flag_a ^ pin_pol))); // R9
    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (!flag_a && !flag_b)); // R1
endmodule

// File: tb/dual_alarm_cmp_tb_top.sv
module dual_alarm_cmp_tb_top;
    localparam int SS_W = 15;
    localparam int PD_W = 15;

    logic clk = 1'b0;
    logic rst_n;
    logic [SS_W-1:0] cal_subsec;
    logic [5:0] cal_sec, cal_min;
    logic [4:0] cal_hour, cal_date;
    logic [2:0] cal_wday;
    logic [PD_W-1:0] presc_div;
    logic [SS_W-1:0] a_subsec, b_subsec;
    logic [5:0] a_sec, a_min, b_sec, b_min;
    logic [4:0] a_hour, a_day, b_hour, b_day, a_mask, b_mask;
    logic a_wdsel, a_ie, a_clr, b_wdsel, b_ie, b_clr;
    logic [1:0] pin_sel;
    logic pin_pol, aux_evt;
    logic flag_a, flag_b, irq, alarm_pin;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dual_alarm_cmp #(.SS_W(SS_W), .PD_W(PD_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cal_subsec(cal_subsec), .cal_sec(cal_sec), .cal_min(cal_min),
        .cal_hour(cal_hour), .cal_date(cal_date), .cal_wday(cal_wday),
        .presc_div(presc_div),
        .a_subsec(a_subsec), .a_sec(a_sec), .a_min(a_min), .a_hour(a_hour),
        .a_day(a_day), .a_wdsel(a_wdsel), .a_mask(a_mask), .a_ie(a_ie), .a_clr(a_clr),
        .b_subsec(b_subsec), .b_sec(b_sec), .b_min(b_min), .b_hour(b_hour),
        .b_day(b_day), .b_wdsel(b_wdsel), .b_mask(b_mask), .b_ie(b_ie), .b_clr(b_clr),
        .pin_sel(pin_sel), .pin_pol(pin_pol), .aux_evt(aux_evt),
        .flag_a(flag_a), .flag_b(flag_b), .irq(irq), .alarm_pin(alarm_pin)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Baseline: calendar 5:20:10.100, date 15, weekday 3; A differs in
    // seconds, B differs in hours; masks clear; flags cleared.
    task automatic baseline();
        cal_subsec = 15'd100; cal_sec = 6'd10; cal_min = 6'd20;
        cal_hour = 5'd5; cal_date = 5'd15; cal_wday = 3'd3;
        a_subsec = 15'd100; a_sec = 6'd11; a_min = 6'd20; a_hour = 5'd5;
        a_day = 5'd15; a_wdsel = 1'b0; a_mask = 5'b0; a_ie = 1'b0;
        b_subsec = 15'd100; b_sec = 6'd10; b_min = 6'd20; b_hour = 5'd6;
        b_day = 5'd15; b_wdsel = 1'b0; b_mask = 5'b0; b_ie = 1'b0;
        pin_sel = 2'b00; pin_pol = 1'b0; aux_evt = 1'b0;
        a_clr = 1'b1; b_clr = 1'b1;
        step();
        a_clr = 1'b0; b_clr = 1'b0;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        baseline();
        cal_sec = 6'd11; // A would match during reset
        pin_sel = 2'b01;
        step();
        check("R1 flag_a in reset", flag_a, 1'b0);
        check("R1 flag_b in reset", flag_b, 1'b0);
        check("R1 irq in reset", irq, 1'b0);
        check("R9 pin inactive after reset", alarm_pin, 1'b0);
        cal_sec = 6'd10;
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_match_a();
        baseline();
        cal_sec = 6'd11;
        step();
        check("R2 flag_a set on full match", flag_a, 1'b1);
        check("R1 flag_b untouched by A", flag_b, 1'b0);
    endtask

    task automatic t_subsec_miss();
        baseline();
        a_sec = 6'd10; a_subsec = 15'd101;
        step();
        check("R2 subsecond mismatch blocks flag", flag_a, 1'b0);
        a_mask = 5'b00001;
        step();
        check("R3 masked subsecond sets flag", flag_a, 1'b1);
    endtask

    task automatic t_hold_clear();
        baseline();
        cal_sec = 6'd11;
        step();
        a_clr = 1'b1;
        step();
        check("R5 clear drops flag", flag_a, 1'b0);
        a_clr = 1'b0;
        step(); step();
        check("R4 held match does not re-set", flag_a, 1'b0);
        cal_sec = 6'd12;
        step();
        cal_sec = 6'd11;
        step();
        check("R4 new match sets again", flag_a, 1'b1);
    endtask

    task automatic t_set_wins();
        baseline();
        cal_sec = 6'd11; a_clr = 1'b1;
        step();
        a_clr = 1'b0;
        check("R5 set wins over clear", flag_a, 1'b1);
    endtask

    task automatic t_mask_b();
        baseline();
        step();
        check("R3 hour mismatch blocks B", flag_b, 1'b0);
        b_mask = 5'b01000;
        step();
        check("R3 masked hour sets B", flag_b, 1'b1);
        check("R1 flag_a untouched by B", flag_a, 1'b0);
        baseline();
        b_mask = 5'b11111; b_subsec = 15'd7; b_sec = 6'd59; b_min = 6'd1; b_hour = 5'd23; b_day = 5'd2;
        step();
        check("R3 all masked matches", flag_b, 1'b1);
    endtask

    task automatic t_daysel();
        baseline();
        a_sec = 6'd10; a_day = 5'd3;
        step();
        check("R6 date compare misses weekday value", flag_a, 1'b0);
        a_wdsel = 1'b1;
        step();
        check("R6 weekday compare matches", flag_a, 1'b1);
        baseline();
        a_sec = 6'd10; a_wdsel = 1'b1; a_day = 5'd15; // low bits 7 vs weekday 3
        step();
        check("R6 weekday mode ignores date", flag_a, 1'b0);
    endtask

    task automatic t_irq();
        baseline();
        cal_sec = 6'd11;
        step();
        check("R7 irq off with enable low", irq, 1'b0);
        b_ie = 1'b1; #1;
        check("R7 other enable does not pass A", irq, 1'b0);
        a_ie = 1'b1; #1;
        check("R7 irq with enabled flag", irq, 1'b1);
    endtask

    task automatic t_pin();
        baseline();
        cal_sec = 6'd11;
        step(); // flag_a=1, flag_b=0
        pin_sel = 2'b00; #1; check("R8 sel 00 inactive", alarm_pin, 1'b0);
        pin_sel = 2'b01; #1; check("R8 sel 01 follows A", alarm_pin, 1'b1);
        pin_sel = 2'b10; #1; check("R8 sel 10 follows B", alarm_pin, 1'b0);
        pin_sel = 2'b11; aux_evt = 1'b1; #1; check("R8 sel 11 follows aux", alarm_pin, 1'b1);
        aux_evt = 1'b0; #1; check("R8 sel 11 aux low", alarm_pin, 1'b0);
        pin_pol = 1'b1; pin_sel = 2'b01; #1; check("R9 active low asserted", alarm_pin, 1'b0);
        pin_sel = 2'b00; #1; check("R9 active low idle", alarm_pin, 1'b1);
    endtask

    initial begin
        presc_div = 15'd255; // R10: divider kept >= 3
        t_reset();
        t_match_a();
        t_subsec_miss();
        t_hold_clear();
        t_set_wins();
        t_mask_b();
        t_daysel();
        t_irq();
        t_pin();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule